// File: doc/BRIEF.md
# Paired Character I/O Controller

This controller joins a byte-wide receive channel and a byte-wide transmit channel behind a simple processor-side I/O port. The processor reads the receive holding register and writes bytes for transmission. It sends a command word whose bits clear the per-channel ready flags or request a single character fetch, and it uses a skip test that reports whether a chosen ready flag is set. Each channel combines its ready flag with an enable bit to form an interrupt request, and the two requests share one output line.

The receive side never pulls bytes from its source without a request. A fetch command arms a delay of `RD_DLY` cycles. When the delay ends, the byte waiting at the source, if there is one, is taken and latched. The transmit side holds a written byte for `WR_DLY` cycles and then presents it to the sink for one cycle. Each channel counts the characters it has moved.

Top module: `pcio_ctrl`

## Requirements
- R1: After reset, in_ready is 0, out_ready is 1, both holding registers are 0 (rd_data reads 0 with rd_en high), both counters are 0, and no fetch or transmission is pending.
- R2: A write (wr_en) keeps only wr_data[7:0] as the transmit byte and clears out_ready from the next cycle.
- R3: Exactly WR_DLY cycles after the write edge, snk_valid is high for one cycle with snk_data equal to the byte, and out_ready rises on the same edge. A write while a byte is still pending replaces that byte and restarts the delay, and only the newer byte reaches the sink.
- R4: A command (fo_en) with fo_cmd bit 2 set arms a fetch. In the last cycle of the RD_DLY-cycle delay, src_take is high if src_valid is high, and on the following edge src_data is latched and in_ready is set. A second fetch command issued while one is pending restarts the delay.
- R5: If src_valid is low when the fetch delay ends, the fetch is dropped: src_take stays low, in_ready stays clear and in_count does not change. Data that appears afterwards is not taken.
- R6: fo_cmd bit 0 clears in_ready and fo_cmd bit 1 clears out_ready. Any combination of the three command bits acts together in one command. A channel completion on the same edge as a clear leaves the flag set.
- R7: sk_result is 1 when (sk_sel[0] and in_ready) or (sk_sel[1] and out_ready), and 0 otherwise.
- R8: rd_data equals the receive holding register while rd_en is high and 0 otherwise. Reading changes no flag.
- R9: in_count and out_count each increase by exactly one per byte received or delivered.
- R10: irq is 1 when (ien_in and in_ready) or (ien_out and out_ready).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | WORD_W | Write data word; only the low byte is kept |
| rd_en | input | 1 | Read strobe for the receive byte |
| rd_data | output | CHAR_W | Receive holding register while rd_en is high |
| fo_en | input | 1 | Command strobe |
| fo_cmd | input | 3 | Command bits: 0 clears receive ready, 1 clears transmit ready, 2 starts a fetch |
| sk_sel | input | 2 | Skip selects: 0 selects receive ready, 1 selects transmit ready |
| sk_result | output | 1 | Skip test result |
| ien_in | input | 1 | Receive interrupt enable |
| ien_out | input | 1 | Transmit interrupt enable |
| irq | output | 1 | Combined interrupt request |
| src_valid | input | 1 | Source has a byte available |
| src_data | input | CHAR_W | Source byte |
| src_take | output | 1 | Source byte consumed on this edge |
| snk_valid | output | 1 | Sink byte valid, one cycle per byte |
| snk_data | output | CHAR_W | Sink byte |
| in_ready | output | 1 | Receive ready flag |
| out_ready | output | 1 | Transmit ready flag |
| in_count | output | CNT_W | Characters received |
| out_count | output | CNT_W | Characters delivered |

## Verification
A delay counter that is off by one moves src_take, snk_valid and the ready flags one cycle early or late, so every fetch and write is sampled in the cycle just before and just after its completion edge. A wrongly prioritised flag update shows as a wrong ready value on the edge where a clear command meets a completion. A wrong reset value shows in out_ready or irq in the first cycle after reset. A lost restart shows as a byte that is delivered or fetched several cycles too early, and a stale byte shows in the sink scoreboard when the sink raises snk_valid.

// File: rtl/pcio_pkg.sv
package pcio_pkg;
  localparam int FO_W       = 3;
  localparam int FO_CLR_IN  = 0;
  localparam int FO_CLR_OUT = 1;
  localparam int FO_START   = 2;
  localparam int SK_W       = 2;
  localparam int CH_IN      = 0;
  localparam int CH_OUT     = 1;
  localparam int NUM_CH     = 2;
endpackage

// File: rtl/pcio_dly_timer.sv
module pcio_dly_timer #(
  parameter int DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expire,
  output logic busy
);
  localparam int CW = (DLY < 2) ? 1 : $clog2(DLY);
  localparam logic [CW-1:0] RELOAD = CW'(DLY - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;
  logic          cnt_en;

  // a fresh load cancels a completion falling in the same cycle
  assign expire = act_q && (cnt_q == '0) && !load;
  assign busy   = act_q;
  assign cnt_en = load || act_q;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (load) begin
      cnt_d = RELOAD;
      act_d = 1'b1;
    end else if (expire) begin
      act_d = 1'b0;
    end else if (act_q) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pcio_rx_chan.sv
module pcio_rx_chan #(
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 16,
  parameter int DLY    = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clr_rdy,
  input  logic              src_valid,
  input  logic [CHAR_W-1:0] src_data,
  output logic              src_take,
  output logic [CHAR_W-1:0] data_o,
  output logic              rdy_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              expire;
  logic              busy;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              rdy_q, rdy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  pcio_dly_timer #(.DLY(DLY)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (start),
    .expire (expire),
    .busy   (busy)
  );

  assign src_take = expire && src_valid;

  always_comb begin
    data_d = data_q;
    rdy_d  = rdy_q;
    cnt_d  = cnt_q;
    if (clr_rdy) rdy_d = 1'b0;
    if (src_take) begin
      data_d = src_data;
      rdy_d  = 1'b1;
      cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      rdy_q <= rdy_d;
      if (src_take) begin
        data_q <= data_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign data_o = data_q;
  assign rdy_o  = rdy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/pcio_tx_chan.sv
module pcio_tx_chan #(
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 16,
  parameter int DLY    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CHAR_W-1:0] wr_byte,
  input  logic              clr_rdy,
  output logic              snk_valid,
  output logic [CHAR_W-1:0] snk_data,
  output logic              rdy_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic              expire;
  logic              busy;
  logic [CHAR_W-1:0] data_q, data_d;
  logic              rdy_q, rdy_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              vld_q;

  pcio_dly_timer #(.DLY(DLY)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (wr),
    .expire (expire),
    .busy   (busy)
  );

  always_comb begin
    data_d = data_q;
    rdy_d  = rdy_q;
    cnt_d  = cnt_q;
    if (clr_rdy) rdy_d = 1'b0;
    if (expire) begin
      rdy_d = 1'b1;
      cnt_d = cnt_q + 1'b1;
    end
    if (wr) begin
      data_d = wr_byte;
      rdy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b1;
      cnt_q  <= '0;
      vld_q  <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      vld_q <= expire;
      if (wr)     data_q <= data_d;
      if (expire) cnt_q  <= cnt_d;
    end
  end

  assign snk_valid = vld_q;
  assign snk_data  = data_q;
  assign rdy_o     = rdy_q;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/pcio_ctrl.sv
module pcio_ctrl
  import pcio_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 16,
  parameter int RD_DLY = 20,
  parameter int WR_DLY = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [CHAR_W-1:0] rd_data,
  input  logic              fo_en,
  input  logic [FO_W-1:0]   fo_cmd,
  input  logic [SK_W-1:0]   sk_sel,
  output logic              sk_result,
  input  logic              ien_in,
  input  logic              ien_out,
  output logic              irq,
  input  logic              src_valid,
  input  logic [CHAR_W-1:0] src_data,
  output logic              src_take,
  output logic              snk_valid,
  output logic [CHAR_W-1:0] snk_data,
  output logic              in_ready,
  output logic              out_ready,
  output logic [CNT_W-1:0]  in_count,
  output logic [CNT_W-1:0]  out_count
);
  logic              clr_in, clr_out, fetch;
  logic [CHAR_W-1:0] in_data;
  logic [NUM_CH-1:0] rdy_vec, ien_vec, req_vec, hit_vec;

  assign clr_in  = fo_en && fo_cmd[FO_CLR_IN];
  assign clr_out = fo_en && fo_cmd[FO_CLR_OUT];
  assign fetch   = fo_en && fo_cmd[FO_START];

  pcio_rx_chan #(.CHAR_W(CHAR_W), .CNT_W(CNT_W), .DLY(RD_DLY)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (fetch),
    .clr_rdy   (clr_in),
    .src_valid (src_valid),
    .src_data  (src_data),
    .src_take  (src_take),
    .data_o    (in_data),
    .rdy_o     (in_ready),
    .cnt_o     (in_count)
  );

  pcio_tx_chan #(.CHAR_W(CHAR_W), .CNT_W(CNT_W), .DLY(WR_DLY)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (wr_en),
    .wr_byte   (wr_data[CHAR_W-1:0]),
    .clr_rdy   (clr_out),
    .snk_valid (snk_valid),
    .snk_data  (snk_data),
    .rdy_o     (out_ready),
    .cnt_o     (out_count)
  );

  assign rdy_vec[CH_IN]  = in_ready;
  assign rdy_vec[CH_OUT] = out_ready;
  assign ien_vec[CH_IN]  = ien_in;
  assign ien_vec[CH_OUT] = ien_out;

  // skip select bit i tests channel i
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign req_vec[g] = rdy_vec[g] && ien_vec[g];
    assign hit_vec[g] = rdy_vec[g] && sk_sel[g];
  end

  assign irq       = |req_vec;
  assign sk_result = |hit_vec;
  assign rd_data   = rd_en ? in_data : '0;
endmodule

// File: rtl/pcio_ctrl_chk.sv
module pcio_ctrl_chk
  import pcio_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [CHAR_W-1:0] rd_data,
  input logic              fo_en,
  input logic [FO_W-1:0]   fo_cmd,
  input logic [SK_W-1:0]   sk_sel,
  input logic              sk_result,
  input logic              src_valid,
  input logic [CHAR_W-1:0] src_data,
  input logic              src_take,
  input logic              snk_valid,
  input logic              in_ready,
  input logic              out_ready,
  input logic [CNT_W-1:0]  in_count,
  input logic [CNT_W-1:0]  out_count
);
  p_wr_clears_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !out_ready);

  p_rise_with_sink_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_ready) |-> snk_valid);

  p_take_latches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    src_take |=> (in_ready && (!rd_en || rd_data == $past(src_data))));

  p_no_data_no_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> (in_count == $past(in_count)));

  p_clr_in_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fo_en && fo_cmd[FO_CLR_IN] && !src_take) |=> !in_ready);

  p_skip_none_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_sel == '0) |-> !sk_result);

  p_read_no_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fo_en && !src_take) |=> (in_ready == $past(in_ready)));

  p_sink_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    snk_valid |-> (out_count == CNT_W'($past(out_count) + 1'b1)));
endmodule

bind pcio_ctrl pcio_ctrl_chk #(.CHAR_W(CHAR_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/pcio_ctrl_tb.sv
module pcio_ctrl_tb;
  localparam int WORD_W = 16;
  localparam int CHAR_W = 8;
  localparam int CNT_W  = 16;
  localparam int RD_DLY = 7;
  localparam int WR_DLY = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_en = 1'b0;
  logic [WORD_W-1:0] wr_data = '0;
  logic              rd_en = 1'b0;
  logic [CHAR_W-1:0] rd_data;
  logic              fo_en = 1'b0;
  logic [2:0]        fo_cmd = '0;
  logic [1:0]        sk_sel = '0;
  logic              sk_result;
  logic              ien_in = 1'b0;
  logic              ien_out = 1'b0;
  logic              irq;
  logic              src_valid = 1'b0;
  logic [CHAR_W-1:0] src_data = '0;
  logic              src_take;
  logic              snk_valid;
  logic [CHAR_W-1:0] snk_data;
  logic              in_ready, out_ready;
  logic [CNT_W-1:0]  in_count, out_count;

  int tests = 0;
  int fails = 0;
  int takes = 0;
  bit done = 1'b0;
  logic [CHAR_W-1:0] sb_q[$];
  logic [CHAR_W-1:0] src_q[$];
  bit take_seen = 1'b0;

  always #10 clk = ~clk;

  pcio_ctrl #(.WORD_W(WORD_W), .CHAR_W(CHAR_W), .CNT_W(CNT_W),
              .RD_DLY(RD_DLY), .WR_DLY(WR_DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .fo_en(fo_en), .fo_cmd(fo_cmd),
    .sk_sel(sk_sel), .sk_result(sk_result), .ien_in(ien_in),
    .ien_out(ien_out), .irq(irq), .src_valid(src_valid),
    .src_data(src_data), .src_take(src_take), .snk_valid(snk_valid),
    .snk_data(snk_data), .in_ready(in_ready), .out_ready(out_ready),
    .in_count(in_count), .out_count(out_count));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [WORD_W-1:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    sb_q.push_back(w[CHAR_W-1:0]);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_fo(logic [2:0] c);
    @(negedge clk);
    fo_en = 1'b1; fo_cmd = c;
    @(negedge clk);
    fo_en = 1'b0; fo_cmd = '0;
  endtask

  // byte source model: pops one cycle after a take
  always @(negedge clk) begin
    if (take_seen) void'(src_q.pop_front());
    take_seen = src_take;
    if (src_take) takes++;
    src_valid = (src_q.size() > 0);
    src_data  = (src_q.size() > 0) ? src_q[0] : '0;
  end

  // sink scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && snk_valid) begin
      if (sb_q.size() == 0) chk("R3 unexpected sink byte", {24'd0, snk_data}, 32'hFFFF_FFFF);
      else chk("R3 sink byte", {24'd0, snk_data}, {24'd0, sb_q.pop_front()});
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);
    rd_en = 1'b1;
    // R1 reset state
    chk("R1 in_ready", in_ready, 0);
    chk("R1 out_ready", out_ready, 1);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 counts", {in_count, out_count}, 0);
    chk("R1 snk_valid", snk_valid, 0);

    // R5 fetch with empty source is dropped
    do_fo(3'b100);
    waitn(RD_DLY + 2);
    chk("R5 in_ready stays clear", in_ready, 0);
    chk("R5 in_count", in_count, 0);
    chk("R5 no take", takes, 0);
    src_q.push_back(8'h99);
    waitn(RD_DLY + 2);
    chk("R5 late data not taken", in_count, 0);
    void'(src_q.pop_front());
    waitn(2);

    // R2 / R3 write and delivery timing
    do_write(16'hA35C);
    chk("R2 out_ready cleared", out_ready, 0);
    waitn(WR_DLY - 1);
    chk("R3 out_ready before delay end", out_ready, 0);
    waitn(1);
    chk("R3 out_ready after delay", out_ready, 1);
    chk("R3 snk_valid", snk_valid, 1);
    chk("R3 snk_data low byte", snk_data, 8'h5C);
    waitn(1);
    chk("R3 snk_valid one cycle", snk_valid, 0);
    chk("R9 out_count", out_count, 1);

    // R7 skip test: in_ready 0, out_ready 1
    sk_sel = 2'b01; #1 chk("R7 sel in", sk_result, 0);
    sk_sel = 2'b10; #1 chk("R7 sel out", sk_result, 1);
    sk_sel = 2'b11; #1 chk("R7 sel both", sk_result, 1);
    sk_sel = 2'b00; #1 chk("R7 sel none", sk_result, 0);

    // R4 fetch with data
    src_q.push_back(8'h3C);
    do_fo(3'b100);
    waitn(RD_DLY - 1);
    chk("R4 in_ready before end", in_ready, 0);
    chk("R4 src_take in last cycle", src_take, 1);
    waitn(1);
    chk("R4 in_ready set", in_ready, 1);
    chk("R4 rd_data", rd_data, 8'h3C);
    chk("R4 src_take drops", src_take, 0);
    chk("R9 in_count", in_count, 1);
    chk("R4 single take", takes, 1);
    sk_sel = 2'b01; #1 chk("R7 sel in set", sk_result, 1);
    sk_sel = 2'b00;

    // R8 reading is side-effect free
    rd_en = 1'b0; #1 chk("R8 rd_data gated", rd_data, 0);
    rd_en = 1'b1;
    waitn(4);
    chk("R8 in_ready kept", in_ready, 1);
    chk("R8 rd_data kept", rd_data, 8'h3C);

    // R10 interrupt
    ien_in = 1'b1; ien_out = 1'b0; #1 chk("R10 irq in", irq, 1);
    ien_in = 1'b0; #1 chk("R10 irq none", irq, 0);
    ien_out = 1'b1; #1 chk("R10 irq out", irq, 1);

    // R6 multi-bit clear
    do_fo(3'b011);
    chk("R6 in_ready cleared", in_ready, 0);
    chk("R6 out_ready cleared", out_ready, 0);
    chk("R10 irq after clear", irq, 0);
    sk_sel = 2'b11; #1 chk("R7 both clear", sk_result, 0);
    sk_sel = 2'b00;

    // R3 restart: newer byte replaces pending one
    do_write(16'h0011);
    void'(sb_q.pop_back());
    do_write(16'h0022);
    waitn(WR_DLY + 2);
    chk("R3 restart count", out_count, 2);
    chk("R3 restart ready", out_ready, 1);

    // R6 completion beats clear on the same edge
    do_write(16'h0077);
    waitn(WR_DLY - 2);
    do_fo(3'b010);
    chk("R6 completion wins", out_ready, 1);
    chk("R9 out_count 3", out_count, 3);

    // R4 restart of pending fetch, combined clear and start
    src_q.push_back(8'h5A);
    do_fo(3'b100);
    waitn(RD_DLY + 1);
    chk("R4 second fetch", rd_data, 8'h5A);
    src_q.push_back(8'hC3);
    do_fo(3'b101);
    chk("R6 clear with start", in_ready, 0);
    waitn(2);
    do_fo(3'b100);
    waitn(RD_DLY - 1);
    chk("R4 restarted not done", in_ready, 0);
    waitn(1);
    chk("R4 restarted done", in_ready, 1);
    chk("R4 restarted data", rd_data, 8'hC3);
    chk("R9 in_count 3", in_count, 3);

    waitn(3);
    chk("R3 scoreboard drained", sb_q.size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule